// File: doc/BRIEF.md
# GPIO port controller with atomic set, clear and toggle

This block is a 32-pin general-purpose I/O port. Software reaches it through a simple memory-mapped bus that carries 32-bit word accesses. The port holds an output latch and a direction word. It also keeps a captured copy of the pin levels. Three write-only alias addresses change chosen bits of the output latch in a single write, with no read-modify-write. A write to the set alias forces the chosen bits to 1, a write to the clear alias forces them to 0, and a write to the toggle alias inverts them.

Each pin is driven only while its direction bit marks it as an output. Pin levels first pass through a synchroniser and are then captured into the input word. That capture is gated by a port enable. The input word reads zero for pins that do not exist and for pins whose digital function is off. A parameter gives the mask of implemented pins.

Every access completes in one cycle. The address decoder turns the word index into one of seven selections: `SEL_DATA`, `SEL_SET`, `SEL_CLR`, `SEL_TGL`, `SEL_IN`, `SEL_DIR` and `SEL_NONE`. These selections steer both the update logic and the read multiplexer. The capture stage has two modes. In track mode (`port_en` = 1) it loads the synchronised pin levels on every clock. In hold mode (`port_en` = 0) it keeps its last value. It changes mode on the first clock edge after `port_en` changes.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the output latch, the direction word and the input word are all 0. Every offset reads 0, and `pin_oe` and `pin_out` are 0.
- R2: A write to offset 0x00 loads the output latch with the written data ANDed with the implemented-pin mask. A read of 0x00 returns the latch in the same cycle, so bits of unimplemented pins read as 0.
- R3: In a write to offset 0x04, each data bit that is 1 sets the matching implemented latch bit. Data bits that are 0 leave their latch bits unchanged.
- R4: In a write to offset 0x08, each data bit that is 1 clears the matching latch bit. Data bits that are 0 leave their latch bits unchanged.
- R5: In a write to offset 0x0C, each data bit that is 1 inverts the matching implemented latch bit. Data bits that are 0 leave their latch bits unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C always return 0.
- R7: Offset 0x14 is the read/write direction word, masked to the implemented pins. A 1 makes the pin an output and a 0 makes it an input. `pin_oe` equals the direction word, and `pin_out` equals the latch ANDed with the direction word.
- R8: Offset 0x10 returns the captured pin levels. A pin change driven before a clock edge shows in a read after the third rising edge, but not in a read after the second.
- R9: An input bit at 0x10 reads 0 whenever its pin is unimplemented or its `pin_digital` bit is 0. The masking takes effect in the same cycle that `pin_digital` changes.
- R10: While `port_en` is 0 the input word keeps its last captured value, whatever the pins do. After `port_en` returns to 1, capture resumes on the following edge.
- R11: A write to 0x10, or a write to any offset above 0x14, changes no register. A read of any offset above 0x14 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, 0 when idle |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_digital | input | 32 | Per-pin digital function enable |
| port_en | input | 1 | Port clock enable gating input capture |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Per-pin output enables |

## Verification
The assertions assume that the bus controls and the write data are known values on every clock edge once reset is released. They also assume that `bus_addr` is word-aligned. `pin_in` is treated as asynchronous and is checked only after it passes the synchroniser. The stimulus draws word-aligned offsets, both inside and beyond the register window, from a fixed-seed generator. It changes `pin_in`, `pin_digital` and `port_en` only at falling edges. During the random phase it holds the pin levels steady, so the captured word has settled before it is compared.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Register selection produced by the address decoder
    typedef enum logic [2:0] {
        SEL_DATA = 3'd0,
        SEL_SET  = 3'd1,
        SEL_CLR  = 3'd2,
        SEL_TGL  = 3'd3,
        SEL_IN   = 3'd4,
        SEL_DIR  = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;

    localparam int unsigned REG_COUNT = 6;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             unused_lsb;

    assign idx        = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        case (idx)
            IDX_W'(0): sel = SEL_DATA;
            IDX_W'(1): sel = SEL_SET;
            IDX_W'(2): sel = SEL_CLR;
            IDX_W'(3): sel = SEL_TGL;
            IDX_W'(4): sel = SEL_IN;
            IDX_W'(5): sel = SEL_DIR;
            default:   sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
    import gpio_port_pkg::*;
#(
    parameter int unsigned         NPINS     = 32,
    parameter logic [NPINS-1:0]    IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] data_q,
    output logic [NPINS-1:0] dir_q
);
    logic [NPINS-1:0] wmask;
    assign wmask = wdata & IMPL_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DATA: data_q <= wmask;
                SEL_SET:  data_q <= data_q | wmask;
                SEL_CLR:  data_q <= data_q & ~wdata;
                SEL_TGL:  data_q <= data_q ^ wmask;
                SEL_DIR:  dir_q  <= wmask;
                default:  begin end
            endcase
        end
    end

    // R3: written ones are set afterwards
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SET) |=>
            ((data_q & $past(wmask)) == $past(wmask)));

    // R4: written ones are clear afterwards, other bits untouched
    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CLR) |=>
            ((data_q & $past(wdata)) == '0 &&
             (data_q & ~$past(wdata)) == ($past(data_q) & ~$past(wdata))));

    // R5: toggle inverts only selected implemented bits
    a_r5_toggle_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_TGL) |=>
            (data_q == ($past(data_q) ^ $past(wmask))));

    // R11: writes to the input word or unmapped offsets change nothing
    a_r11_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_IN || sel == SEL_NONE)) |=>
            ($stable(data_q) && $stable(dir_q)));

    // R2: unimplemented bits never become set
    a_r2_impl_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_q & ~IMPL_MASK) == '0 && (dir_q & ~IMPL_MASK) == '0));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] in_q
);
    logic [NPINS-1:0] stage [SYNC_STAGES];

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= '0;
                else        stage[0] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    // Track mode loads every edge, hold mode keeps the last value
    always_ff @(posedge clk) begin
        if (!rst_n)      in_q <= '0;
        else if (cap_en) in_q <= stage[SYNC_STAGES-1];
    end

    // R10: hold mode freezes the captured word
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(in_q));

    // R8: track mode loads the last synchroniser stage
    a_r8_track: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (in_q == $past(stage[SYNC_STAGES-1])));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned      NPINS       = 32,
    parameter int unsigned      ADDR_W      = 8,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [NPINS-1:0] IMPL_MASK   = 32'h00FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  pin_digital,
    input  logic              port_en,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);
    reg_sel_e         sel;
    logic             wr_en;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] in_q;

    assign wr_en = bus_valid && bus_write;

    gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_out_reg #(.NPINS(NPINS), .IMPL_MASK(IMPL_MASK)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (bus_wdata),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    gpio_in_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (port_en),
        .pin_in (pin_in),
        .in_q   (in_q)
    );

    assign pin_oe  = dir_q;
    assign pin_out = data_q & dir_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_valid) begin
            unique case (sel)
                SEL_DATA: bus_rdata = data_q;
                SEL_IN:   bus_rdata = in_q & pin_digital & IMPL_MASK;
                SEL_DIR:  bus_rdata = dir_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R6: alias offsets read zero
    a_r6_alias_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (sel == SEL_SET || sel == SEL_CLR || sel == SEL_TGL))
            |-> (bus_rdata == '0));

    // R7: a pin is never driven high unless enabled as output
    a_r7_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    // R9: input read never shows non-digital or missing pins
    a_r9_input_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && sel == SEL_IN) |->
            ((bus_rdata & ~(pin_digital & IMPL_MASK)) == '0));

    // R11: unmapped offsets read zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
    localparam logic [31:0] IMPL = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_digital = '1;
    logic        port_en = 1'b1;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_data = '0;
    logic [31:0] m_dir  = '0;
    logic [31:0] m_in   = '0;

    always #5 clk = ~clk;

    gpio_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_digital(pin_digital), .port_en(port_en),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_data;
            8'h10:   return m_in & pin_digital & IMPL;
            8'h14:   return m_dir;
            default: return 32'h0;
        endcase
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h00: m_data = d & IMPL;
            8'h04: m_data = m_data | (d & IMPL);
            8'h08: m_data = m_data & ~d;
            8'h0C: m_data = m_data ^ (d & IMPL);
            8'h14: m_dir  = d & IMPL;
            default: ;
        endcase
    endfunction

    // Called at a falling edge; returns at the next falling edge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a);
        logic [31:0] v;
        bus_rd(a, v);
        check(tag, v, exp_read(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] old_in;
        void'($urandom(32'd20240611));
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        for (int a = 0; a < 6; a++) rd_check("R1 reset read", 8'(a * 4));

        // R2 plain write, unimplemented bits masked
        bus_wr(8'h00, 32'hFFFF_FFFF);
        rd_check("R2 data all ones", 8'h00);
        bus_wr(8'h00, 32'h0012_3400);
        rd_check("R2 data pattern", 8'h00);

        // R3 set
        bus_wr(8'h04, 32'hFF00_000F);
        rd_check("R3 set", 8'h00);
        check("R3 set value", exp_read(8'h00), 32'h0012_340F);
        // R4 clear
        bus_wr(8'h08, 32'h0000_3005);
        rd_check("R4 clear", 8'h00);
        // R5 toggle
        bus_wr(8'h0C, 32'hF0F0_00FF);
        rd_check("R5 toggle", 8'h00);
        bus_wr(8'h0C, 32'h0000_0000);
        rd_check("R5 toggle zero no change", 8'h00);

        // R6 aliases read zero
        rd_check("R6 set alias", 8'h04);
        rd_check("R6 clear alias", 8'h08);
        rd_check("R6 toggle alias", 8'h0C);

        // R7 direction
        bus_wr(8'h14, 32'hFF00_F0F0);
        rd_check("R7 dir readback", 8'h14);
        check("R7 pin_oe", pin_oe, m_dir);
        check("R7 pin_out", pin_out, m_data & m_dir);

        // R8 synchroniser latency
        pin_in = 32'hA5A5_5A5A;
        idle(2);
        rd_check("R8 not yet visible", 8'h10);
        m_in = 32'hA5A5_5A5A;
        rd_check("R8 visible after third edge", 8'h10);

        // R9 digital mask and unimplemented pins
        pin_digital = 32'h0000_FFFF;
        rd_check("R9 digital mask", 8'h10);
        pin_digital = 32'hFFFF_FFFF;
        rd_check("R9 unimplemented pins zero", 8'h10);
        check("R9 upper byte", exp_read(8'h10) & 32'hFF00_0000, 32'h0);

        // R10 freeze while port disabled
        port_en = 1'b0;
        pin_in  = 32'h0F0F_F0F0;
        idle(5);
        rd_check("R10 frozen", 8'h10);
        port_en = 1'b1;
        idle(1);
        m_in = 32'h0F0F_F0F0;
        rd_check("R10 resumes", 8'h10);

        // R11 ignored writes and unmapped reads
        old_in = exp_read(8'h10);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_rd(8'h10, v);
        check("R11 input write ignored", v, old_in);
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_wr(8'hFC, 32'h1234_5678);
        rd_check("R11 data unchanged", 8'h00);
        rd_check("R11 dir unchanged", 8'h14);
        rd_check("R11 unmapped read 0x18", 8'h18);
        rd_check("R11 unmapped read 0xFC", 8'hFC);

        // Random phase, pins held steady
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            a = 8'($urandom_range(0, 15) * 4);
            if ($urandom_range(0, 7) == 0) pin_digital = $urandom();
            if ($urandom_range(0, 1) == 1) bus_wr(a, $urandom());
            else rd_check("R2-R6 R11 random read", a);
            check("R7 random pin_oe", pin_oe, m_dir);
            check("R7 random pin_out", pin_out, m_data & m_dir);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule